// File: doc/BRIEF.md
# Latched-Address Static RAM Cycle Sequencer

The block sits between a simple host request port and the pins of a 1024 x 1 asynchronous static RAM. That RAM takes its address at the moment its active-low enable drops. The host hands over one request at a time: an address, a read/write flag and a write bit. The sequencer then drives the RAM pins through a fixed, parameterised pattern. It presents the address with enable high. It pulls enable low to latch the address and holds the address stable. For a write, it pulses the active-low write strobe. For a read, it waits until the RAM output has settled and samples it. Finally it raises enable and keeps it high for a recovery interval before the next cycle may begin.

Every interval is a parameter counted in clock cycles, each at least 1: address setup before the enable edge, address hold after it, read output-valid wait, write data-to-strobe-rise time, and enable-high recovery. A one-cycle response strobe closes each request. It returns the read bit for reads and a zero for writes.

Top module: `lat_ram_seq`

## Requirements
- R1: While reset is asserted and just after it, ram_en_no and ram_we_no are 1, req_ready_o is 1 and rsp_valid_o is 0.
- R2: A request is taken only on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o stays 0 from that edge until the recovery interval has ended, and a request held valid meanwhile is not taken early.
- R3: ram_addr_o equals the request address for at least SETUP_CYC cycles before ram_en_no falls. It does not change while ram_en_no is low, which covers the HOLD_CYC hold window.
- R4: In a read, ram_we_no stays 1 for the whole cycle. ram_q_i is sampled at the clock edge ending the cycle in which ram_en_no has been low for HOLD_CYC + VALID_CYC + 1 cycles, never earlier. That bit is returned on rsp_rdata_o.
- R5: In a write, ram_we_no is low for exactly WSETUP_CYC cycles, only while ram_en_no is low. ram_d_o is stable during the strobe and for one cycle after it rises. ram_en_no rises one cycle after ram_we_no rises.
- R6: rsp_valid_o is high for exactly one cycle, SETUP_CYC + HOLD_CYC + L + 1 clock edges after the accepting edge, where L is VALID_CYC for reads and WSETUP_CYC for writes. rsp_rdata_o is 0 for writes.
- R7: ram_en_no stays high for at least RECOVER_CYC cycles between two enable-low periods. req_ready_o returns to 1 exactly RECOVER_CYC cycles after the response cycle.
- R8: A read returns the bit most recently written to that address, including the lowest (0) and highest (1023) addresses. Writes to other addresses do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Sequencer idle and able to take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | 1 | Bit to write |
| rsp_valid_o | output | 1 | One-cycle completion strobe |
| rsp_rdata_o | output | 1 | Read bit (0 for writes) |
| ram_en_no | output | 1 | RAM enable, active low; address latched on its falling edge |
| ram_we_no | output | 1 | RAM write strobe, active low |
| ram_addr_o | output | AW | RAM address |
| ram_d_o | output | 1 | RAM write data |
| ram_q_i | input | 1 | RAM read data |

## Verification
The bench models the RAM so that its output carries the inverted stored bit until enable has been low for the output-valid time. A sample taken one edge early therefore returns a wrong bit instead of a lucky match. Writes and reads run at both ends of the address range and on neighbouring addresses. This separates correct address latching from aliasing and from stale data. Mixed random traffic, with the host holding valid through recovery, tells a sequencer that respects the recovery window apart from one that restarts early. Per-request latency checks show whether the read and write paths each use their own access length.

// File: rtl/lat_ram_pkg.sv
package lat_ram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LATCH,
    ST_ACCESS,
    ST_SAMPLE,
    ST_RECOVER
  } seq_state_e;
endpackage

// File: rtl/lat_ram_fsm.sv
module lat_ram_fsm
  import lat_ram_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int HOLD_CYC    = 1,
  parameter int VALID_CYC   = 3,
  parameter int WSETUP_CYC  = 2,
  parameter int RECOVER_CYC = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       write_i,
  output seq_state_e state_o
);
  localparam int M1   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int M2   = (VALID_CYC > WSETUP_CYC) ? VALID_CYC : WSETUP_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > RECOVER_CYC) ? M3 : RECOVER_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, load_val;
  logic          load, last;

  assign last    = (cnt_q == '0);
  assign state_o = state_q;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_SETUP;
        load     = 1'b1;
        load_val = CW'(SETUP_CYC - 1);
      end
      ST_SETUP: if (last) begin
        state_d  = ST_LATCH;
        load     = 1'b1;
        load_val = CW'(HOLD_CYC - 1);
      end
      ST_LATCH: if (last) begin
        state_d  = ST_ACCESS;
        load     = 1'b1;
        load_val = write_i ? CW'(WSETUP_CYC - 1) : CW'(VALID_CYC - 1);
      end
      ST_ACCESS: if (last) begin
        state_d = ST_SAMPLE;
        load    = 1'b1;
      end
      ST_SAMPLE: begin
        state_d  = ST_RECOVER;
        load     = 1'b1;
        load_val = CW'(RECOVER_CYC - 1);
      end
      ST_RECOVER: if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load)        cnt_q <= load_val;
      else if (!last)  cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  recover_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOVER) |=> (state_q inside {ST_RECOVER, ST_IDLE}));

  // R6
  sample_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAMPLE) |=> (state_q == ST_RECOVER));
endmodule

// File: rtl/lat_ram_pins.sv
module lat_ram_pins
  import lat_ram_pkg::*;
#(
  parameter int AW          = 10,
  parameter int SETUP_CYC   = 2,
  parameter int RECOVER_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_wdata_i,
  input  seq_state_e    state_i,
  input  logic          ram_q_i,
  output logic          wr_o,
  output logic          ram_en_no,
  output logic          ram_we_no,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_d_o,
  output logic          rsp_valid_o,
  output logic          rsp_rdata_o
);
  localparam int KMAX = (SETUP_CYC > RECOVER_CYC) ? SETUP_CYC : RECOVER_CYC;
  localparam int KW   = $clog2(KMAX + 2) + 1;

  logic [AW-1:0] addr_q;
  logic          wr_q, wd_q, rsp_v_q, rsp_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      wd_q   <= 1'b0;
    end else if (accept_i) begin
      addr_q <= req_addr_i;
      wr_q   <= req_write_i;
      wd_q   <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= 1'b0;
    end else begin
      rsp_v_q <= (state_i == ST_SAMPLE);
      if (state_i == ST_SAMPLE) rsp_d_q <= wr_q ? 1'b0 : ram_q_i;
    end
  end

  assign ram_en_no   = !(state_i inside {ST_LATCH, ST_ACCESS, ST_SAMPLE});
  assign ram_we_no   = !(wr_q && (state_i == ST_ACCESS));
  assign ram_addr_o  = addr_q;
  assign ram_d_o     = wd_q;
  assign wr_o        = wr_q;
  assign rsp_valid_o = rsp_v_q;
  assign rsp_rdata_o = rsp_d_q;

  // checker-side counters
  logic [AW-1:0] addr_seen_q;
  logic [KW-1:0] stab_q, hi_q;
  logic          been_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_seen_q <= '0;
      stab_q      <= '0;
      hi_q        <= '0;
      been_low_q  <= 1'b0;
    end else begin
      addr_seen_q <= ram_addr_o;
      if (ram_addr_o != addr_seen_q) stab_q <= '0;
      else if (stab_q != '1)         stab_q <= stab_q + 1'b1;
      if (!ram_en_no)                hi_q   <= '0;
      else if (hi_q != '1)           hi_q   <= hi_q + 1'b1;
      if (!ram_en_no)                been_low_q <= 1'b1;
    end
  end

  // R3
  addr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_en_no) |-> (stab_q >= KW'(SETUP_CYC - 1)));

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_en_no && !$past(ram_en_no)) |-> $stable(ram_addr_o));

  // R4
  read_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_en_no && !wr_o) |-> ram_we_no);

  // R5
  strobe_in_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> !ram_en_no);

  // R5
  enable_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_en_no) |-> $past(ram_we_no));

  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_no) |-> $stable(ram_d_o));

  // R6
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R7
  recovery_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ram_en_no) && been_low_q) |-> (hi_q >= KW'(RECOVER_CYC)));
endmodule

// File: rtl/lat_ram_seq.sv
module lat_ram_seq
  import lat_ram_pkg::*;
#(
  parameter int AW          = 10,
  parameter int SETUP_CYC   = 2,
  parameter int HOLD_CYC    = 1,
  parameter int VALID_CYC   = 3,
  parameter int WSETUP_CYC  = 2,
  parameter int RECOVER_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_rdata_o,
  output logic          ram_en_no,
  output logic          ram_we_no,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_d_o,
  input  logic          ram_q_i
);
  seq_state_e state;
  logic       accept, wr;

  assign req_ready_o = (state == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  lat_ram_fsm #(
    .SETUP_CYC  (SETUP_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .VALID_CYC  (VALID_CYC),
    .WSETUP_CYC (WSETUP_CYC),
    .RECOVER_CYC(RECOVER_CYC)
  ) i_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .write_i(wr),
    .state_o(state)
  );

  lat_ram_pins #(
    .AW         (AW),
    .SETUP_CYC  (SETUP_CYC),
    .RECOVER_CYC(RECOVER_CYC)
  ) i_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .state_i    (state),
    .ram_q_i    (ram_q_i),
    .wr_o       (wr),
    .ram_en_no  (ram_en_no),
    .ram_we_no  (ram_we_no),
    .ram_addr_o (ram_addr_o),
    .ram_d_o    (ram_d_o),
    .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o)
  );

  // R2
  ready_only_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> ram_en_no);
endmodule

// File: tb/test_lat_ram_seq.sv
module test_lat_ram_seq;
  localparam int AW = 10;
  localparam int S  = 2;
  localparam int H  = 1;
  localparam int V  = 3;
  localparam int W  = 2;
  localparam int R  = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready_o, rsp_valid_o, rsp_rdata_o;
  logic ram_en_n, ram_we_n, ram_d, ram_q;
  logic [AW-1:0] ram_addr;

  always #4 clk = ~clk;

  lat_ram_seq #(.AW(AW), .SETUP_CYC(S), .HOLD_CYC(H), .VALID_CYC(V),
                .WSETUP_CYC(W), .RECOVER_CYC(R)) i_lat_ram_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .ram_en_no(ram_en_n), .ram_we_no(ram_we_n), .ram_addr_o(ram_addr),
    .ram_d_o(ram_d), .ram_q_i(ram_q));

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- behavioural RAM model ----------------
  logic [DEPTH-1:0] mem = '0;
  logic [AW-1:0] lat = '0, prev_addr = '0;
  logic prev_en = 1'b1, prev_we = 1'b1, prev_d = 1'b0, seen_low = 1'b0;
  int lo_cnt = 0, hi_cnt = 0, stab = 0, we_lo = 0;

  assign ram_q = (!ram_en_n && lo_cnt >= H + V) ? mem[lat] : ~mem[lat];

  always @(posedge clk) begin
    if (!rst_n) begin
      prev_en <= 1'b1; prev_we <= 1'b1; lo_cnt <= 0; hi_cnt <= 0;
      stab <= 0; we_lo <= 0; seen_low <= 1'b0;
    end else begin
      int st;
      st = (ram_addr == prev_addr) ? stab + 1 : 0;
      stab <= st;
      prev_addr <= ram_addr;
      prev_en <= ram_en_n;
      prev_we <= ram_we_n;
      prev_d  <= ram_d;
      hi_cnt  <= ram_en_n ? hi_cnt + 1 : 0;
      if (prev_en && !ram_en_n) begin
        lat <= ram_addr;
        lo_cnt <= 1;
        chk("R3 setup", (st >= S) ? 1 : 0, 1);
        if (seen_low) chk("R7 recovery", (hi_cnt >= R) ? 1 : 0, 1);
        seen_low <= 1'b1;
      end else if (!ram_en_n) begin
        lo_cnt <= lo_cnt + 1;
        if (lo_cnt < H && ram_addr != lat) chk("R3 hold", int'(ram_addr), int'(lat));
      end
      if (!ram_we_n) begin
        we_lo <= we_lo + 1;
        if (!prev_we && ram_d != prev_d) chk("R5 data stable", int'(ram_d), int'(prev_d));
        if (ram_en_n) chk("R5 strobe inside enable", 1, 0);
      end
      if (!prev_we && ram_we_n) begin
        mem[lat] <= ram_d;
        we_lo <= 0;
        chk("R5 strobe width", we_lo, W);
        chk("R5 enable still low after strobe", int'(ram_en_n), 0);
      end
      if (prev_we && !prev_en && ram_en_n && ram_d != prev_d)
        chk("R5 data hold", int'(ram_d), int'(prev_d));
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit wr; bit exp; int acc; } exp_t;
  exp_t sb[$];
  logic [DEPTH-1:0] shadow = '0;
  int last_rsp = -1;

  task automatic send(input bit wr, input int addr, input bit b);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr[AW-1:0]; req_wdata = b;
    while (!req_ready_o) @(negedge clk);
    @(posedge clk); #1;
    e.wr = wr; e.exp = wr ? 1'b0 : shadow[addr]; e.acc = cyc;
    if (wr) shadow[addr] = b;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid_o) begin
        if (sb.size() == 0) chk("R6 unexpected response", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk("R6 latency", cyc - e.acc, S + H + (e.wr ? W : V) + 1);
          if (e.wr) chk("R6 write rdata", int'(rsp_rdata_o), 0);
          else      chk("R4/R8 read data", int'(rsp_rdata_o), int'(e.exp));
        end
        last_rsp = cyc;
      end
      if (last_rsp >= 0 && cyc >= last_rsp && cyc < last_rsp + R)
        chk("R2/R7 ready low in recovery", int'(req_ready_o), 0);
      if (last_rsp >= 0 && cyc == last_rsp + R)
        chk("R7 ready returns", int'(req_ready_o), 1);
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 en", int'(ram_en_n), 1);
    chk("R1 we", int'(ram_we_n), 1);
    chk("R1 ready", int'(req_ready_o), 1);
    chk("R1 rsp", int'(rsp_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 en after release", int'(ram_en_n), 1);
    chk("R1 ready after release", int'(req_ready_o), 1);

    // R8 boundary addresses and neighbours
    send(1, 0, 1);
    send(1, DEPTH - 1, 1);
    send(1, 1, 0);
    send(0, 0, 0);
    send(0, DEPTH - 1, 0);
    send(0, 1, 0);
    send(1, DEPTH - 2, 1);
    send(0, DEPTH - 1, 0);
    send(0, DEPTH - 2, 0);
    send(1, 0, 0);
    send(0, 0, 0);
    // R4 alternating pattern
    for (int i = 0; i < 16; i++) send(1, 100 + i, i[0]);
    for (int i = 0; i < 16; i++) send(0, 100 + i, 0);
    for (int i = 0; i < 16; i++) send(1, 100 + i, ~i[0]);
    for (int i = 15; i >= 0; i--) send(0, 100 + i, 0);
    // mixed random traffic (R2, R6, R7)
    for (int i = 0; i < 300; i++) begin
      int a;
      a = $urandom_range(0, 31) * 32 + $urandom_range(0, 1);
      send($urandom_range(0, 1), a, $urandom_range(0, 1));
    end
    repeat (S + H + V + R + 6) @(negedge clk);
    chk("R6 all responses seen", sb.size(), 0);
    finish_run();
  end
endmodule